// File: doc/BRIEF.md
# Multicast cell buffer manager

This block keeps a pool of fixed-size cell slots and decides which slot each new cell occupies, which transmit queues it waits on and when its slot can be reused. Free slots are chained into a single linked list whose link word sits in word 0 of the free slot itself. Once a slot is handed out, word 0 holds the 32-bit cell header instead and the link no longer has any meaning. Each slot also keeps a 16-bit VC number, a 2-bit source tag and a multicast count, which together form the record's trailer word. Payload words are carried elsewhere and are not modelled here.

An allocation names a destination mask with one bit for each transmit queue. The slot pointer is appended to every queue whose bit is set, and the multicast count is loaded with the number of queues that actually took it. A mask with one bit set is an ordinary unicast. Each queue hands pointers out through its own valid/ready port. When the transmitter has sent a cell, it reports the slot on the transmit-done input. Each report lowers the count by one, and the report that lowers it to zero puts the slot back at the head of the free list.

Back-pressure rules. `alloc_ready` is high whenever a slot can be supplied, and it never depends on `alloc_valid`. An allocation takes place only on a cycle where both are high. While `alloc_ready` is low, `alloc_valid` may stay high, and nothing changes. Queue `i` presents its front pointer with `deq_valid[i]`. The pointer is removed only on a cycle where `deq_ready[i]` is also high. While `deq_ready[i]` is low, the same pointer stays presented.

Top module: `mcast_cell_mgr`

## Requirements
- R1: After reset, every slot is free and chained in ascending order with slot 0 at the head. `alloc_slot` is 0, `alloc_empty` is low, all queues are empty, and `q_overflow` is all zero.
- R2: An accepted allocation takes the slot at the head of the free list, and `alloc_slot` shows that slot before the edge. The free list is last-in first-out, so a slot that was just freed is the next one handed out.
- R3: An accepted allocation appends the slot to the tail of every queue that takes it. Each queue hands pointers out in arrival order.
- R4: The multicast count of an allocated slot equals the number of queues that took the slot. It can be read on `rd_mcount`, and a free slot reads 0.
- R5: Each transmit-done report on a slot with a nonzero count lowers the count by one. Only the report that lowers the count from 1 to 0 returns the slot to the head of the free list.
- R6: A transmit-done report on a slot whose count is 0 is ignored: no count changes and the free list is unchanged.
- R7: While no slot is free and no slot is being freed in the same cycle, `alloc_empty` is high and `alloc_ready` is low. An allocation request in that state changes nothing.
- R8: When a transmit-done report frees a slot in the same cycle as an accepted allocation, the freed slot is the one allocated. This holds even when the free list is empty.
- R9: The header, the VC number and the source tag written at allocation can be read back on `rd_hdr`, `rd_vc` and `rd_port`. The source tag encodes 00 as receive port A, 01 as receive port B, 10 as the transmit AAL2 path and 11 as the transmit CPU path.
- R10: If a mask bit names a full queue, that queue is skipped and its bit in `q_overflow` is set and stays set until reset. If no named queue can take the cell, including when the mask is zero, no slot is consumed.
- R11: `deq_valid[i]` is high exactly when queue `i` holds a pointer, and `deq_slot` shows that queue's front pointer. A pointer leaves the queue only when `deq_valid[i]` and `deq_ready[i]` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | A slot can be supplied this cycle |
| alloc_mask | input | NQ | Destination queue mask |
| alloc_hdr | input | 32 | Cell header stored in word 0 |
| alloc_vc | input | 16 | VC number stored in the trailer |
| alloc_port | input | 2 | Source tag (R9 encoding) |
| alloc_slot | output | PW | Slot that the next accepted allocation receives |
| alloc_empty | output | 1 | No slot is available |
| deq_valid | output | NQ | Queue holds a pointer, one bit per queue |
| deq_ready | input | NQ | Consumer takes the front pointer, one bit per queue |
| deq_slot | output | NQ*PW | Front pointer of each queue, queue i in bits [i*PW +: PW] |
| done_valid | input | 1 | Transmit-done report |
| done_slot | input | PW | Slot that was sent |
| rd_slot | input | PW | Record read address |
| rd_hdr | output | 32 | Word 0 of the slot (the header while the slot is allocated) |
| rd_vc | output | 16 | Stored VC number |
| rd_port | output | 2 | Stored source tag |
| rd_mcount | output | CW | Remaining sends |
| q_full | output | NQ | Queue full flags |
| q_overflow | output | NQ | Sticky overflow flags |

## Verification
The hardest case to reach from the ports is a release and an allocation in the same cycle while the free list is already empty. Only then does the freed slot have to bypass the list entirely. The stimulus reaches it by handing out every slot as unicast cells spread over the queues, then confirming that allocation is refused. It then dequeues one cell and reports it sent on the same cycle that a new allocation is requested. Queue overflow is forced in a directed phase that fills one queue and then aims a two-queue mask at it, followed by a mask that names only the full queue. A long seeded random phase then mixes multicast masks, dequeues and transmit-done reports in varying interleavings.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  // Source tag carried in the record trailer
  typedef enum logic [1:0] {
    SRC_RX_A    = 2'b00,
    SRC_RX_B    = 2'b01,
    SRC_TX_AAL2 = 2'b10,
    SRC_TX_CPU  = 2'b11
  } src_tag_e;
endpackage

// File: rtl/mcm_ptr_fifo.sv
module mcm_ptr_fifo #(
  parameter int PW    = 4,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [PW-1:0] push_slot,
  input  logic          pop,
  output logic [PW-1:0] front,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);

  logic [PW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign front = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) begin
        mem[wp[AW-1:0]] <= push_slot;
        wp <= wp + 1'b1;
      end
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/mcm_free_list.sv
module mcm_free_list #(
  parameter int NSLOT = 16,
  parameter int PW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give,
  input  logic [PW-1:0] give_slot,
  input  logic [PW-1:0] head_link,
  output logic [PW-1:0] head,
  output logic          none_free
);
  localparam int NW = $clog2(NSLOT + 1);

  logic [NW-1:0] cnt;

  assign none_free = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      cnt  <= NW'(NSLOT);
    end else begin
      unique case ({take, give})
        2'b01: begin            // released slot becomes the new head
          head <= give_slot;
          cnt  <= cnt + 1'b1;
        end
        2'b10: begin            // head handed out, follow its link
          head <= head_link;
          cnt  <= cnt - 1'b1;
        end
        default: ;              // idle, or released slot handed straight out
      endcase
    end
  end
endmodule

// File: rtl/mcm_cell_store.sv
module mcm_cell_store #(
  parameter int NSLOT = 16,
  parameter int PW    = 4,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  // link write when a slot joins the free list
  input  logic          link_we,
  input  logic [PW-1:0] link_slot,
  input  logic [PW-1:0] link_val,
  // record write on allocation
  input  logic          rec_we,
  input  logic [PW-1:0] rec_slot,
  input  logic [31:0]   rec_hdr,
  input  logic [15:0]   rec_vc,
  input  logic [1:0]    rec_port,
  input  logic [CW-1:0] rec_mc,
  // count decrement on transmit done
  input  logic          dec_we,
  input  logic [PW-1:0] dec_slot,
  output logic [CW-1:0] dec_mc,
  // free-list head link lookup
  input  logic [PW-1:0] head_slot,
  output logic [PW-1:0] head_link,
  // record read port
  input  logic [PW-1:0] rd_slot,
  output logic [31:0]   rd_hdr,
  output logic [15:0]   rd_vc,
  output logic [1:0]    rd_port,
  output logic [CW-1:0] rd_mc
);
  logic [31:0]   word0 [NSLOT];  // link while free, header while allocated
  logic [15:0]   vc_m  [NSLOT];
  logic [1:0]    pt_m  [NSLOT];
  logic [CW-1:0] mc_m  [NSLOT];

  assign dec_mc    = mc_m[dec_slot];
  assign head_link = word0[head_slot][PW-1:0];
  assign rd_hdr    = word0[rd_slot];
  assign rd_vc     = vc_m[rd_slot];
  assign rd_port   = pt_m[rd_slot];
  assign rd_mc     = mc_m[rd_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        word0[i] <= 32'(i + 1);
        vc_m[i]  <= '0;
        pt_m[i]  <= '0;
        mc_m[i]  <= '0;
      end
    end else begin
      if (dec_we) mc_m[dec_slot] <= dec_mc - 1'b1;
      if (link_we) word0[link_slot] <= 32'(link_val);
      if (rec_we) begin            // a fresh record overrides both writes above
        word0[rec_slot] <= rec_hdr;
        vc_m[rec_slot]  <= rec_vc;
        pt_m[rec_slot]  <= rec_port;
        mc_m[rec_slot]  <= rec_mc;
      end
    end
  end
endmodule

// File: rtl/mcast_cell_mgr.sv
module mcast_cell_mgr #(
  parameter int NSLOT  = 16,
  parameter int NQ     = 4,
  parameter int QDEPTH = 8,
  localparam int PW    = $clog2(NSLOT),
  localparam int CW    = $clog2(NQ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  output logic             alloc_ready,
  input  logic [NQ-1:0]    alloc_mask,
  input  logic [31:0]      alloc_hdr,
  input  logic [15:0]      alloc_vc,
  input  logic [1:0]       alloc_port,
  output logic [PW-1:0]    alloc_slot,
  output logic             alloc_empty,
  output logic [NQ-1:0]    deq_valid,
  input  logic [NQ-1:0]    deq_ready,
  output logic [NQ*PW-1:0] deq_slot,
  input  logic             done_valid,
  input  logic [PW-1:0]    done_slot,
  input  logic [PW-1:0]    rd_slot,
  output logic [31:0]      rd_hdr,
  output logic [15:0]      rd_vc,
  output logic [1:0]       rd_port,
  output logic [CW-1:0]    rd_mcount,
  output logic [NQ-1:0]    q_full,
  output logic [NQ-1:0]    q_overflow
);
  import mcm_pkg::*;

  logic [PW-1:0] head, head_link;
  logic          none_free;
  logic [CW-1:0] done_mc;
  logic          dec, freeing, hs, take;
  logic [NQ-1:0] eff_mask, q_empty;
  src_tag_e      tag_in;

  assign tag_in = src_tag_e'(alloc_port);

  // transmit done: count down, release on the last send
  assign dec     = done_valid && (done_mc != '0);
  assign freeing = dec && (done_mc == CW'(1));

  // allocation side
  assign alloc_empty = none_free && !freeing;
  assign alloc_ready = !alloc_empty;
  assign alloc_slot  = freeing ? done_slot : head;
  assign hs          = alloc_valid && alloc_ready;
  assign eff_mask    = alloc_mask & ~q_full;
  assign take        = hs && (eff_mask != '0);

  mcm_free_list #(.NSLOT(NSLOT), .PW(PW)) free_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .give      (freeing),
    .give_slot (done_slot),
    .head_link (head_link),
    .head      (head),
    .none_free (none_free)
  );

  mcm_cell_store #(.NSLOT(NSLOT), .PW(PW), .CW(CW)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_we   (freeing && !take),
    .link_slot (done_slot),
    .link_val  (head),
    .rec_we    (take),
    .rec_slot  (alloc_slot),
    .rec_hdr   (alloc_hdr),
    .rec_vc    (alloc_vc),
    .rec_port  (tag_in),
    .rec_mc    (CW'($countones(eff_mask))),
    .dec_we    (dec),
    .dec_slot  (done_slot),
    .dec_mc    (done_mc),
    .head_slot (head),
    .head_link (head_link),
    .rd_slot   (rd_slot),
    .rd_hdr    (rd_hdr),
    .rd_vc     (rd_vc),
    .rd_port   (rd_port),
    .rd_mc     (rd_mcount)
  );

  for (genvar g = 0; g < NQ; g++) begin : g_q
    mcm_ptr_fifo #(.PW(PW), .DEPTH(QDEPTH)) fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (take && eff_mask[g]),
      .push_slot (alloc_slot),
      .pop       (deq_ready[g]),
      .front     (deq_slot[g*PW +: PW]),
      .full      (q_full[g]),
      .empty     (q_empty[g])
    );
    assign deq_valid[g] = !q_empty[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q_overflow <= '0;
    else if (hs) q_overflow <= q_overflow | (alloc_mask & q_full);
  end
endmodule

// File: rtl/mcm_checker.sv
module mcm_checker #(
  parameter int NQ = 4,
  parameter int PW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic             alloc_empty,
  input logic             none_free,
  input logic             freeing,
  input logic [NQ-1:0]    deq_valid,
  input logic [NQ-1:0]    deq_ready,
  input logic [NQ*PW-1:0] deq_slot,
  input logic [NQ-1:0]    q_overflow
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!alloc_empty && deq_valid == '0 && q_overflow == '0));

  // R7
  empty_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_empty |-> !alloc_ready);

  // R8
  bypass_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (none_free && freeing) |-> alloc_ready);

  // R5
  release_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeing && !alloc_valid) |=> !alloc_empty);

  // R10
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_overflow & $past(q_overflow)) == $past(q_overflow)));

  for (genvar g = 0; g < NQ; g++) begin : g_hold
    // R11
    deq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_valid[g] && !deq_ready[g]) |=> (deq_valid[g] && $stable(deq_slot[g*PW +: PW])));
  end
endmodule

bind mcast_cell_mgr mcm_checker #(.NQ(NQ), .PW(PW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .alloc_empty (alloc_empty),
  .none_free   (none_free),
  .freeing     (freeing),
  .deq_valid   (deq_valid),
  .deq_ready   (deq_ready),
  .deq_slot    (deq_slot),
  .q_overflow  (q_overflow)
);

// File: tb/mcast_cell_mgr_tb_top.sv
module mcast_cell_mgr_tb_top;
  localparam int PERIOD = 10;
  localparam int NSLOT  = 16;
  localparam int NQ     = 4;
  localparam int QDEPTH = 8;
  localparam int PW     = $clog2(NSLOT);
  localparam int CW     = $clog2(NQ + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0, done_valid = 1'b0;
  logic [NQ-1:0] alloc_mask = '0, deq_ready = '0;
  logic [31:0] alloc_hdr = '0;
  logic [15:0] alloc_vc = '0;
  logic [1:0]  alloc_port = '0;
  logic [PW-1:0] done_slot = '0, rd_slot = '0;
  logic alloc_ready, alloc_empty;
  logic [PW-1:0] alloc_slot;
  logic [NQ-1:0] deq_valid, q_full, q_overflow;
  logic [NQ*PW-1:0] deq_slot;
  logic [31:0] rd_hdr;
  logic [15:0] rd_vc;
  logic [1:0]  rd_port;
  logic [CW-1:0] rd_mcount;

  always #(PERIOD/2) clk = ~clk;

  mcast_cell_mgr #(.NSLOT(NSLOT), .NQ(NQ), .QDEPTH(QDEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_mask(alloc_mask), .alloc_hdr(alloc_hdr), .alloc_vc(alloc_vc),
    .alloc_port(alloc_port), .alloc_slot(alloc_slot), .alloc_empty(alloc_empty),
    .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_slot(deq_slot),
    .done_valid(done_valid), .done_slot(done_slot), .rd_slot(rd_slot),
    .rd_hdr(rd_hdr), .rd_vc(rd_vc), .rd_port(rd_port), .rd_mcount(rd_mcount),
    .q_full(q_full), .q_overflow(q_overflow)
  );

  // reference model
  int m_free[$];
  int m_q[NQ][$];
  int pend[$];
  int m_mc[NSLOT];
  logic [31:0] m_hdr[NSLOT];
  logic [15:0] m_vc[NSLOT];
  logic [1:0]  m_pt[NSLOT];
  logic [NQ-1:0] m_ovf;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit ended = 0;
  string tag = "";

  task automatic chk(string req, string what, longint act, longint exp);
    string t;
    t = (tag != "") ? tag : req;
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic finish_run();
    ended = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic int popc(logic [NQ-1:0] v);
    int n = 0;
    for (int i = 0; i < NQ; i++) n += v[i];
    return n;
  endfunction

  task automatic model_reset();
    m_free.delete();
    for (int i = 0; i < NSLOT; i++) begin
      m_free.push_back(i);
      m_mc[i] = 0;
    end
    for (int i = 0; i < NQ; i++) m_q[i].delete();
    pend.delete();
    m_ovf = '0;
  endtask

  // one cycle: drive, check pre-edge outputs, update the model, take the edge
  task automatic step(bit av, logic [NQ-1:0] mask, logic [NQ-1:0] dr, bit dv, int ds);
    bit fr, ex_empty, hs;
    logic [NQ-1:0] full, eff;
    int slot, rs;
    @(negedge clk);
    alloc_valid = av; alloc_mask = mask; deq_ready = dr;
    done_valid = dv; done_slot = PW'(ds);
    alloc_hdr = $urandom; alloc_vc = 16'($urandom); alloc_port = 2'($urandom);
    rs = $urandom % NSLOT;
    rd_slot = PW'(rs);
    #1;
    fr = dv && (m_mc[ds] == 1);
    ex_empty = (m_free.size() == 0) && !fr;
    chk("R7", "alloc_empty", alloc_empty, ex_empty);
    chk("R7", "alloc_ready", alloc_ready, !ex_empty);
    if (!ex_empty) chk(fr ? "R8" : "R2", "alloc_slot", alloc_slot, fr ? ds : m_free[0]);
    for (int i = 0; i < NQ; i++) begin
      full[i] = (m_q[i].size() == QDEPTH);
      chk("R11", "deq_valid", deq_valid[i], m_q[i].size() != 0);
      if (m_q[i].size() != 0) chk("R3", "deq_slot", deq_slot[i*PW +: PW], m_q[i][0]);
    end
    chk("R10", "q_full", q_full, full);
    chk("R10", "q_overflow", q_overflow, m_ovf);
    chk("R4", "rd_mcount", rd_mcount, m_mc[rs]);
    if (m_mc[rs] != 0) begin
      chk("R9", "rd_hdr", rd_hdr, m_hdr[rs]);
      chk("R9", "rd_vc", rd_vc, m_vc[rs]);
      chk("R9", "rd_port", rd_port, m_pt[rs]);
    end
    // model update
    for (int i = 0; i < NQ; i++)
      if (dr[i] && m_q[i].size() != 0) pend.push_back(m_q[i].pop_front());
    if (dv && m_mc[ds] != 0) m_mc[ds]--;
    if (fr) m_free.push_front(ds);
    hs = av && !ex_empty;
    if (hs) begin
      eff = mask & ~full;
      m_ovf |= mask & full;
      if (eff != '0) begin
        slot = m_free.pop_front();
        m_mc[slot] = popc(eff);
        m_hdr[slot] = alloc_hdr; m_vc[slot] = alloc_vc; m_pt[slot] = alloc_port;
        for (int i = 0; i < NQ; i++) if (eff[i]) m_q[i].push_back(slot);
      end
    end
  endtask

  task automatic idle();
    step(0, '0, '0, 0, 0);
  endtask

  task automatic drain();
    int s;
    while (pend.size() != 0 || m_q[0].size() != 0 || m_q[1].size() != 0 ||
           m_q[2].size() != 0 || m_q[3].size() != 0) begin
      if (pend.size() != 0) begin
        s = pend.pop_front();
        step(0, '0, '1, 1, s);
      end else step(0, '0, '1, 0, 0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !ended) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  initial begin
    int s, idx, ds;
    bit dv;
    void'($urandom(32'h5eed_0c11));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state, head is slot 0
    tag = "R1";
    idle();
    idle();

    // R10: fill queue 1, overflow with a two-queue mask, then a mask naming only the full queue
    tag = "R10";
    for (int i = 0; i < QDEPTH; i++) step(1, 4'b0010, '0, 0, 0);
    step(1, 4'b0011, '0, 0, 0);
    step(1, 4'b0010, '0, 0, 0);
    step(1, 4'b0000, '0, 0, 0);
    idle();
    tag = "";
    drain();

    // R5: multicast to two queues, only the second send releases the slot
    tag = "R5";
    step(1, 4'b0101, '0, 0, 0);
    step(0, '0, 4'b0101, 0, 0);
    s = pend.pop_front();
    step(0, '0, '0, 1, s);
    idle();
    s = pend.pop_front();
    step(0, '0, '0, 1, s);
    idle();

    // R6: a done report on a free slot is ignored
    tag = "R6";
    step(0, '0, '0, 1, m_free[1]);
    idle();
    step(1, 4'b1000, '0, 0, 0);
    tag = "";
    drain();

    // R7: exhaust the pool, then request with nothing free
    tag = "R7";
    for (int i = 0; i < NSLOT; i++) step(1, NQ'(1 << (i % NQ)), '0, 0, 0);
    step(1, 4'b0001, '0, 0, 0);
    idle();
    // R8: release and allocate in the same cycle with the list empty
    tag = "R8";
    step(0, '0, 4'b0001, 0, 0);
    s = pend.pop_front();
    step(1, 4'b0100, '0, 1, s);
    idle();
    tag = "";
    drain();

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      dv = (pend.size() != 0) && ($urandom % 2 == 1);
      ds = $urandom % NSLOT;
      if (dv) begin
        idx = $urandom % pend.size();
        ds = pend[idx];
        pend.delete(idx);
      end else if ($urandom % 16 == 0) begin
        dv = 1;                               // stray report, model decides its effect
        if (m_free.size() != 0) ds = m_free[0];
        else dv = 0;
      end
      step($urandom % 2, NQ'($urandom), NQ'($urandom), dv, ds);
    end
    drain();
    idle();
    finish_run();
  end
endmodule